// File: doc/BRIEF.md
# Byte-Wide Interrupt Controller with Periodic Timer

This block collects eight interrupt requests for a small 8-bit processor. The requests sit in one byte-wide register. A read/write enable byte selects which requests may drive a single level-sensitive interrupt line. Two write-only strobe locations clear or raise request bits. Software uses them to acknowledge interrupts and to raise its own general-purpose interrupts.

Two peripheral completion signals, transmit-complete and serial-access-complete, are edge-captured into their own request bits. An internal periodic timer raises request bit 0. Its period is a programmable count of reference ticks. Each tick is a one-cycle strobe in the system clock domain, one per period of a 32.768 kHz reference (about 30.52 µs).

The timer is a two-state machine. In state TMR_IDLE it does nothing. In state TMR_COUNT it counts ticks. A write of a non-zero period takes the IDLE→COUNT transition, or restarts COUNT→COUNT. A write of zero takes the COUNT→IDLE transition, or stays in IDLE. While in COUNT, the tick that completes a period fires the timer request and sends the count back to zero.

Top module: `irqc_top`

## Requirements
- R1: After reset, the request, enable and period registers are all zero, the interrupt line is low, and the timer is in TMR_IDLE.
- R2: Reads are combinational on `bus_rdata`. Offset 2 returns the request byte, offset 3 returns the enable byte, and offset 6 returns the period. Every other offset (0, 1, 4, 5, 7) reads as zero. A write to offset 3 replaces the enable byte at the next clock edge.
- R3: `irq_o` is high exactly when some request bit and the same enable bit are both 1. It stays high until that request is cleared or disabled.
- R4: A write to offset 4 clears each request bit whose data bit is 1. Request bits whose data bit is 0 keep their value.
- R5: A write to offset 5 sets each request bit whose data bit is 1. Bit 0 is the timer, bit 1 is transmit-complete, bit 2 is serial-access-complete, and bits 5 to 7 are general-purpose. Bits 3 and 4 are unused and always read 0.
- R6: A rising edge on `txd_done` sets request bit 1, and a rising edge on `sad_done` sets request bit 2. The request becomes visible after the first clock edge at which the input is high. An input held high sets its bit only once.
- R7: If a hardware set and a clear of the same bit fall on the same clock edge, the bit ends up set.
- R8: Offset 6 holds the timer period and can be read and written. A period of zero keeps the timer in TMR_IDLE, and request bit 0 is then never raised by the timer.
- R9: With a non-zero period N, request bit 0 is set on the edge that samples the Nth `ref_tick` after the period write, and again every N ticks after that. A tick that falls in the write cycle is not counted, and any write to offset 6 restarts the count.
- R10: A write to offset 2 has no effect on the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed location |
| bus_addr | input | 3 | Byte offset of the location within the controller |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| ref_tick | input | 1 | One-cycle strobe per reference-clock period |
| txd_done | input | 1 | Transmit-complete signal, edge-captured into bit 1 |
| sad_done | input | 1 | Serial-access-complete signal, edge-captured into bit 2 |
| irq_o | output | 1 | Level interrupt line to the processor |

## Verification
The hardest case to reach from the ports is a hardware set and a software clear of the same bit on one edge. This needs a rising edge on a completion input in the exact cycle that the clear write is sampled. The bench drives the input's rising edge and the clear write in the same stimulus slot. It also lets a long random phase, with frequent ticks and short periods, land timer expiries on clear writes and on period rewrites. A behavioural model predicts the interrupt line and the read data in every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Bus geometry
    localparam int DW = 8;
    localparam int AW = 3;

    // Location offsets (the processor software relies on these)
    localparam logic [AW-1:0] OFS_REQ    = 3'd2;
    localparam logic [AW-1:0] OFS_ENA    = 3'd3;
    localparam logic [AW-1:0] OFS_CLR    = 3'd4;
    localparam logic [AW-1:0] OFS_SET    = 3'd5;
    localparam logic [AW-1:0] OFS_PERIOD = 3'd6;

    // Request bit positions
    localparam int BIT_TMR = 0;
    localparam int BIT_TXD = 1;
    localparam int BIT_SAD = 2;

    // Bits that exist as storage (3 and 4 are unused)
    localparam logic [DW-1:0] REQ_LIVE = 8'b1110_0111;

    // Number of edge-captured peripheral inputs
    localparam int N_PERIPH = 2;

    typedef enum logic [0:0] {
        TMR_IDLE  = 1'b0,
        TMR_COUNT = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= lvl[g];
            end
        end

        assign rise[g] = lvl[g] & ~prev_q[g];
    end

endmodule

// File: rtl/irqc_timer.sv
module irqc_timer
    import irqc_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_tick,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic [TW-1:0] period,
    output logic          fire
);

    tmr_state_e    state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic          at_end;

    assign at_end = (cnt_q == period - TW'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (load) begin
            cnt_d   = '0;
            state_d = (load_val == '0) ? TMR_IDLE : TMR_COUNT;
        end else begin
            unique case (state_q)
                TMR_IDLE: begin
                    cnt_d = '0;
                end
                TMR_COUNT: begin
                    if (ref_tick) begin
                        cnt_d = at_end ? '0 : cnt_q + TW'(1);
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            TMR_IDLE:  fire = 1'b0;
            TMR_COUNT: fire = !load && ref_tick && at_end;
        endcase
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int DWID = DW,
    parameter int AWID = AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [AWID-1:0] bus_addr,
    input  logic [DWID-1:0] bus_wdata,
    input  logic [DWID-1:0] hw_set,
    output logic [DWID-1:0] req_q,
    output logic [DWID-1:0] ena_q,
    output logic [DWID-1:0] period_q,
    output logic            period_load,
    output logic [DWID-1:0] bus_rdata
);

    logic            wr_ena, wr_clr, wr_set;
    logic [DWID-1:0] sw_clr, sw_set, req_d;

    assign wr_ena      = bus_we && (bus_addr == OFS_ENA);
    assign wr_clr      = bus_we && (bus_addr == OFS_CLR);
    assign wr_set      = bus_we && (bus_addr == OFS_SET);
    assign period_load = bus_we && (bus_addr == OFS_PERIOD);

    assign sw_clr = wr_clr ? bus_wdata : '0;
    assign sw_set = wr_set ? bus_wdata : '0;

    // Any set source overrides a clear of the same bit
    assign req_d = ((req_q & ~sw_clr) | sw_set | hw_set) & REQ_LIVE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q    <= '0;
            ena_q    <= '0;
            period_q <= '0;
        end else begin
            req_q <= req_d;
            if (wr_ena) begin
                ena_q <= bus_wdata;
            end
            if (period_load) begin
                period_q <= bus_wdata;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_REQ:    bus_rdata = req_q;
            OFS_ENA:    bus_rdata = ena_q;
            OFS_PERIOD: bus_rdata = period_q;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ref_tick,
    input  logic          txd_done,
    input  logic          sad_done,
    output logic          irq_o
);

    logic [N_PERIPH-1:0] periph_lvl, periph_rise;
    logic [DW-1:0]       hw_set, req_q, ena_q, period_q;
    logic                tmr_fire, period_load;

    assign periph_lvl = {sad_done, txd_done};

    irqc_edge #(.N(N_PERIPH)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (periph_lvl),
        .rise (periph_rise)
    );

    irqc_timer #(.TW(DW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_tick(ref_tick),
        .load    (period_load),
        .load_val(bus_wdata),
        .period  (period_q),
        .fire    (tmr_fire)
    );

    always_comb begin
        hw_set          = '0;
        hw_set[BIT_TMR] = tmr_fire;
        hw_set[BIT_TXD] = periph_rise[0];
        hw_set[BIT_SAD] = periph_rise[1];
    end

    irqc_regs #(.DWID(DW), .AWID(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .hw_set     (hw_set),
        .req_q      (req_q),
        .ena_q      (ena_q),
        .period_q   (period_q),
        .period_load(period_load),
        .bus_rdata  (bus_rdata)
    );

    assign irq_o = |(req_q & ena_q);

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          ref_tick,
    input logic [DW-1:0] req_q,
    input logic [DW-1:0] ena_q,
    input logic [DW-1:0] period_q,
    input logic [DW-1:0] hw_set,
    input logic          tmr_fire,
    input logic          irq_o
);

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CLR) |=> ((req_q & $past(bus_wdata) & ~$past(hw_set)) == '0)); // R4

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CLR && hw_set != '0) |=> ((req_q & $past(hw_set)) == $past(hw_set))); // R7

    AST_SW_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_SET) |=> ((req_q & $past(bus_wdata)) == ($past(bus_wdata) & REQ_LIVE))); // R5

    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_we && (bus_addr == OFS_CLR || bus_addr == OFS_SET)) && hw_set == '0) |=> $stable(req_q)); // R10

    AST_TMR_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (period_q == '0) |-> !tmr_fire); // R8

    AST_FIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_fire |-> ref_tick); // R9

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_q == '0) |-> !irq_o); // R3

endmodule

bind irqc_top irqc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .ref_tick (ref_tick),
    .req_q    (req_q),
    .ena_q    (ena_q),
    .period_q (period_q),
    .hw_set   (hw_set),
    .tmr_fire (tmr_fire),
    .irq_o    (irq_o)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;

    localparam int CLK_P = 10;
    localparam int Q     = CLK_P / 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ref_tick = 1'b0;
    logic       txd_done = 1'b0;
    logic       sad_done = 1'b0;
    logic       irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    irqc_top i_irqc_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ref_tick (ref_tick),
        .txd_done (txd_done),
        .sad_done (sad_done),
        .irq_o    (irq_o)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_req, m_ena, m_per;
    int         m_cnt;
    logic       m_ptx, m_psa;

    always @(posedge clk) begin
        logic [7:0] s, c;
        if (!rst_n) begin
            m_req = 0; m_ena = 0; m_per = 0; m_cnt = 0; m_ptx = 0; m_psa = 0;
        end else begin
            s = 0; c = 0;
            if (txd_done && !m_ptx) s[1] = 1'b1;
            if (sad_done && !m_psa) s[2] = 1'b1;
            m_ptx = txd_done; m_psa = sad_done;
            if (bus_we && bus_addr == 3'd6) begin
                m_per = bus_wdata; m_cnt = 0;
            end else if (m_per != 0 && ref_tick) begin
                if (m_cnt == int'(m_per) - 1) begin
                    m_cnt = 0; s[0] = 1'b1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (bus_we) begin
                case (bus_addr)
                    3'd3: m_ena = bus_wdata;
                    3'd4: c = bus_wdata;
                    3'd5: s = s | bus_wdata;
                    default: ;
                endcase
            end
            m_req = ((m_req & ~c) | s) & 8'hE7;
        end
    end

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd2: return m_req;
            3'd3: return m_ena;
            3'd6: return m_per;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            check("R3 irq level", {7'b0, irq_o}, {7'b0, |(m_req & m_ena)});
            check("R2 read data", bus_rdata, m_read(bus_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #Q;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #Q;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #Q;
        bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        check(tag, bus_rdata, exp);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #Q; ref_tick = 1'b1;
            @(posedge clk); #Q; ref_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    // ---------------- directed and random sequence ----------------
    initial begin
        idle(4);
        #Q rst_n = 1'b1;
        // R1 reset state
        rd(3'd2, 8'h00, "R1 requests after reset");
        rd(3'd3, 8'h00, "R1 enable after reset");
        rd(3'd6, 8'h00, "R1 period after reset");
        check("R1 irq after reset", {7'b0, irq_o}, 8'h00);

        // R2 enable register and unused offsets
        wr(3'd3, 8'hFF);
        rd(3'd3, 8'hFF, "R2 enable readback");
        rd(3'd0, 8'h00, "R2 offset 0 reads zero");
        rd(3'd7, 8'h00, "R2 offset 7 reads zero");

        // R5 software set, unused bits stay zero
        wr(3'd5, 8'hFF);
        rd(3'd2, 8'hE7, "R5 set all live bits");
        check("R3 irq raised", {7'b0, irq_o}, 8'h01);

        // R4 clear only the one bits
        wr(3'd4, 8'h21);
        rd(3'd2, 8'hC6, "R4 selective clear");

        // R10 write to request location ignored
        wr(3'd2, 8'h00);
        rd(3'd2, 8'hC6, "R10 request write ignored");

        wr(3'd4, 8'hFF);
        rd(3'd2, 8'h00, "R4 clear all");
        check("R3 irq drops", {7'b0, irq_o}, 8'h00);

        // R3 enable gating
        wr(3'd3, 8'h02);
        wr(3'd5, 8'h80);
        check("R3 disabled request no irq", {7'b0, irq_o}, 8'h00);
        wr(3'd4, 8'h80);

        // R6 edge capture of a held input
        @(posedge clk); #Q txd_done = 1'b1;
        idle(3);
        rd(3'd2, 8'h02, "R6 txd edge captured");
        check("R3 enabled request irq", {7'b0, irq_o}, 8'h01);
        wr(3'd4, 8'h02);
        idle(2);
        rd(3'd2, 8'h00, "R6 held input sets once");
        @(posedge clk); #Q txd_done = 1'b0;

        // R7 set beats clear on the same edge
        @(posedge clk); #Q;
        sad_done = 1'b1; bus_we = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h04;
        @(posedge clk); #Q;
        bus_we = 1'b0; sad_done = 1'b0;
        rd(3'd2, 8'h04, "R7 set wins over clear");
        wr(3'd4, 8'hFF);

        // R8 period zero keeps timer off
        wr(3'd6, 8'h00);
        tick(10);
        rd(3'd2, 8'h00, "R8 zero period no timer request");

        // R9 timer period of 3
        wr(3'd6, 8'h03);
        rd(3'd6, 8'h03, "R8 period readback");
        tick(2);
        rd(3'd2, 8'h00, "R9 no request before third tick");
        tick(1);
        rd(3'd2, 8'h01, "R9 request on third tick");
        wr(3'd4, 8'h01);
        tick(2);
        rd(3'd2, 8'h00, "R9 reload no early request");
        tick(1);
        rd(3'd2, 8'h01, "R9 periodic request");
        wr(3'd4, 8'h01);
        tick(2);
        wr(3'd6, 8'h03);
        tick(2);
        rd(3'd2, 8'h00, "R9 period write restarts count");
        tick(1);
        rd(3'd2, 8'h01, "R9 request after restart");

        // Random phase, compared to the model every cycle
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #Q;
            bus_we    = ($urandom_range(0, 3) == 0);
            bus_addr  = 3'($urandom_range(0, 7));
            bus_wdata = 8'($urandom_range(0, 255));
            if (bus_addr == 3'd6) bus_wdata = 8'($urandom_range(0, 5));
            ref_tick  = ($urandom_range(0, 2) == 0);
            txd_done  = ($urandom_range(0, 3) == 0) ? ~txd_done : txd_done;
            sad_done  = ($urandom_range(0, 3) == 0) ? ~sad_done : sad_done;
        end
        @(posedge clk); #Q;
        bus_we = 1'b0; ref_tick = 1'b0;
        idle(3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule